// File: doc/BRIEF.md
# Maskable Clear-on-Read Interrupt Aggregator

This block collects sixteen single-cycle event pulses from surrounding logic into two 8-bit status banks. Each bank has a matching 8-bit enable register. A pulse always latches its status bit, whatever the enable setting. The active-low request line `irq_n_o` is driven low whenever a latched status bit is also enabled.

Software reaches the banks through a simple strobe/address port. Reading a status bank returns its contents and, at the same clock edge, clears only the bits of that bank that are enabled. The request line is released once no enabled bit stays pending. Disabled bits stay latched, so they can be polled. Such a bit raises the request as soon as its enable is set, and the next read of its bank clears it.

Bank 0 holds, from bit 7 down to bit 0: FIFO error, TX FIFO almost full, TX FIFO almost empty, RX FIFO almost full, external, packet sent, packet valid, CRC error. Bank 1 holds, from bit 7 down to bit 0: sync detected, preamble valid, preamble invalid, RSSI, wake-up timer, low battery, chip ready, power-on reset. In the default configuration, only the power-on-reset source is enabled after reset.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous reset, both status banks are 00h, enable bank 0 reads 00h, enable bank 1 reads 01h, `irq_n_o` is 1 and `rdata_o` is 00h.
- R2: A 1 on `evt_i[8*b+k]` sets bit k of status bank b at that clock edge, whether or not the bit is enabled. Bank 0 is read at address 03h and bank 1 at address 04h.
- R3: `irq_n_o` is registered. After each edge it is 0 exactly when some status bit and its enable bit are both 1, so an enabled event drives it low at the edge that latches the event.
- R4: A read (`req_i`=1, `we_i`=0) of a status address loads the pre-clear bank value into `rdata_o` at that edge. At the same edge it clears every bit of that bank that is enabled.
- R5: A status read leaves bits whose enable is 0 set.
- R6: An event arriving in the same cycle as a clearing read of its bank leaves its bit set.
- R7: A write (`we_i`=1) to address 05h or 06h loads enable bank 0 or 1. Reads of 05h and 06h return the stored enables. A read of any other unmapped address returns 00h. `rdata_o` holds its value when no read is made.
- R8: Writes to the status addresses 03h and 04h change no state.
- R9: Events on disabled bits leave `irq_n_o` at 1.
- R10: Enabling an already-latched status bit drives `irq_n_o` low at the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 16 | Event pulses, bank b bit k at index 8*b+k |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench aims at the clear mask. If a read cleared the whole bank, disabled polled bits would disappear after the first read. If a read cleared nothing, the request would never release. It also collides an event with a clearing read of the same bank. A design that gives the clear priority loses that event and leaves the request high. Other targets are the non-zero enable reset value, which a design resetting to zero would leave the power-on source masked, and writes to status addresses, which a loose decoder would let through. A behavioural model is compared on every cycle across a long random access mix.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int unsigned REG_W = 8;
  typedef logic [REG_W-1:0] reg_t;
  typedef enum logic [1:0] {ACC_NONE, ACC_RD, ACC_WR} acc_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] EN_RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         rd_clr_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         pend_nxt_o
);
  logic [W-1:0] clr_mask;
  logic [W-1:0] stat_nxt;
  logic [W-1:0] en_nxt;

  always_comb begin
    clr_mask   = rd_clr_i ? en_o : '0;
    stat_nxt   = (stat_o & ~clr_mask) | evt_i;
    en_nxt     = wr_en_i ? wdata_i : en_o;
    pend_nxt_o = |(stat_nxt & en_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o <= '0;
      en_o   <= EN_RST;
    end else begin
      stat_o <= stat_nxt;
      en_o   <= en_nxt;
    end
  end

  p_evt_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

  p_rd_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_clr_i && evt_i == '0) |=> ((stat_o & $past(en_o)) == '0));

  p_rd_keeps_masked_r5: assert property (@(posedge clk) disable iff (rst)
    rd_clr_i |=> ((stat_o & ~$past(en_o) & $past(stat_o)) == ($past(stat_o) & ~$past(en_o))));

  p_no_clear_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!rd_clr_i && evt_i == '0) |=> $stable(stat_o));
endmodule

// File: rtl/irq_decode.sv
module irq_decode
  import irq_pkg::*;
#(
  parameter int unsigned NB        = 2,
  parameter int unsigned W         = 8,
  parameter int unsigned AW        = 8,
  parameter int unsigned STAT_BASE = 3,
  parameter int unsigned EN_BASE   = 5
) (
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NB*W-1:0] stat_i,
  input  logic [NB*W-1:0] en_i,
  output logic [NB-1:0]   rd_clr_o,
  output logic [NB-1:0]   wr_en_o,
  output logic            rd_vld_o,
  output logic [W-1:0]    rd_data_o
);
  acc_e acc;
  logic [NB-1:0] hit_stat;
  logic [NB-1:0] hit_en;

  always_comb begin
    if (!req_i)    acc = ACC_NONE;
    else if (we_i) acc = ACC_WR;
    else           acc = ACC_RD;
  end

  for (genvar b = 0; b < NB; b++) begin : g_dec
    localparam logic [AW-1:0] SA = AW'(STAT_BASE + b);
    localparam logic [AW-1:0] EA = AW'(EN_BASE + b);
    assign hit_stat[b] = (addr_i == SA);
    assign hit_en[b]   = (addr_i == EA);
    assign rd_clr_o[b] = (acc == ACC_RD) && hit_stat[b];
    assign wr_en_o[b]  = (acc == ACC_WR) && hit_en[b];
  end

  assign rd_vld_o = (acc == ACC_RD);

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (hit_stat[b]) rd_data_o = rd_data_o | stat_i[b*W +: W];
      if (hit_en[b])   rd_data_o = rd_data_o | en_i[b*W +: W];
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter int unsigned NB        = 2,
  parameter int unsigned W         = REG_W,
  parameter int unsigned AW        = 8,
  parameter int unsigned STAT_BASE = 3,
  parameter int unsigned EN_BASE   = 5,
  parameter logic [NB*W-1:0] EN_RST = 16'h0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NB*W-1:0] evt_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    rdata_o,
  output logic            irq_n_o
);
  localparam int unsigned NSRC = NB * W;

  logic [NSRC-1:0] stat;
  logic [NSRC-1:0] en;
  logic [NB-1:0]   rd_clr;
  logic [NB-1:0]   wr_en;
  logic [NB-1:0]   pend_nxt;
  logic            rd_vld;
  logic [W-1:0]    rd_data;

  irq_decode #(.NB(NB), .W(W), .AW(AW), .STAT_BASE(STAT_BASE), .EN_BASE(EN_BASE)) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .stat_i(stat), .en_i(en),
    .rd_clr_o(rd_clr), .wr_en_o(wr_en), .rd_vld_o(rd_vld), .rd_data_o(rd_data)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    irq_bank #(.W(W), .EN_RST(EN_RST[b*W +: W])) u_bank (
      .clk(clk), .rst(rst), .evt_i(evt_i[b*W +: W]),
      .rd_clr_i(rd_clr[b]), .wr_en_i(wr_en[b]), .wdata_i(wdata_i),
      .stat_o(stat[b*W +: W]), .en_o(en[b*W +: W]), .pend_nxt_o(pend_nxt[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_n_o <= 1'b1;
    end else begin
      if (rd_vld) rdata_o <= rd_data;
      irq_n_o <= ~|pend_nxt;
    end
  end

  p_irq_level_r3: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == ~|(stat & en));

  p_rd_value_r4: assert property (@(posedge clk) disable iff (rst)
    (req_i && !we_i && addr_i == AW'(STAT_BASE)) |=> (rdata_o == $past(stat[W-1:0])));

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic        clk = 0;
  logic        rst = 1;
  logic [15:0] evt = '0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic        irq_n;

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";

  logic [7:0] m_stat [2];
  logic [7:0] m_en   [2];
  logic [7:0] m_rd;
  logic       m_irq_n;

  always #4 clk = ~clk;

  irq_aggregator dut (
    .clk(clk), .rst(rst), .evt_i(evt), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_stat[0] = 0; m_stat[1] = 0; m_en[0] = 8'h00; m_en[1] = 8'h01;
      m_rd = 0; m_irq_n = 1;
    end else begin
      if (req && !we) begin
        case (addr)
          8'h03: m_rd = m_stat[0];
          8'h04: m_rd = m_stat[1];
          8'h05: m_rd = m_en[0];
          8'h06: m_rd = m_en[1];
          default: m_rd = 0;
        endcase
        if (addr == 8'h03) m_stat[0] = m_stat[0] & ~m_en[0];
        if (addr == 8'h04) m_stat[1] = m_stat[1] & ~m_en[1];
      end
      if (req && we && addr == 8'h05) m_en[0] = wdata;
      if (req && we && addr == 8'h06) m_en[1] = wdata;
      m_stat[0] = m_stat[0] | evt[7:0];
      m_stat[1] = m_stat[1] | evt[15:8];
      m_irq_n = ((m_stat[0] & m_en[0]) | (m_stat[1] & m_en[1])) == 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst && cyc > 2) begin
      chk(rdata === m_rd, {cur_req, " rdata"}, rdata, m_rd);
      chk(irq_n === m_irq_n, {cur_req, " irq_n"}, irq_n, m_irq_n);
    end
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0; d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    req = 1; we = 1; addr = a; wdata = v;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic pulse(input logic [15:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk(irq_n === 1'b1, "R1 irq_n after reset", irq_n, 1);
    chk(rdata === 8'h00, "R1 rdata after reset", rdata, 0);
    rd(8'h05, d); chk(d === 8'h00, "R1 enable0 reset", d, 8'h00);
    rd(8'h06, d); chk(d === 8'h01, "R1 enable1 reset", d, 8'h01);
    rd(8'h03, d); chk(d === 8'h00, "R1 status0 reset", d, 8'h00);

    cur_req = "R9";
    pulse(16'h0008);
    chk(irq_n === 1'b1, "R9 disabled event no irq", irq_n, 1);
    cur_req = "R5";
    rd(8'h03, d); chk(d === 8'h08, "R2 status latched while disabled", d, 8'h08);
    rd(8'h03, d); chk(d === 8'h08, "R5 disabled bit kept after read", d, 8'h08);

    cur_req = "R10";
    wr(8'h05, 8'h08);
    chk(irq_n === 1'b0, "R10 enabling pending bit", irq_n, 0);
    cur_req = "R4";
    rd(8'h03, d);
    chk(d === 8'h08, "R4 read returns pre-clear", d, 8'h08);
    chk(irq_n === 1'b1, "R4 irq released", irq_n, 1);
    rd(8'h03, d); chk(d === 8'h00, "R4 bit cleared", d, 8'h00);

    cur_req = "R3";
    pulse(16'h0100);
    chk(irq_n === 1'b0, "R3 enabled event asserts irq", irq_n, 0);
    rd(8'h04, d); chk(d === 8'h01, "R2 bank1 bit0", d, 8'h01);
    chk(irq_n === 1'b1, "R3 irq high after read", irq_n, 1);

    cur_req = "R8";
    pulse(16'h0010);
    wr(8'h03, 8'hFF);
    wr(8'h04, 8'hFF);
    rd(8'h03, d); chk(d === 8'h10, "R8 status0 write ignored", d, 8'h10);
    rd(8'h04, d); chk(d === 8'h00, "R8 status1 write ignored", d, 8'h00);

    cur_req = "R6";
    evt = 16'h0008; req = 1; we = 0; addr = 8'h03;
    @(negedge clk);
    evt = '0; req = 0;
    chk(rdata === 8'h10, "R6 read value before event", rdata, 8'h10);
    chk(irq_n === 1'b0, "R6 colliding event keeps irq", irq_n, 0);
    rd(8'h03, d); chk(d === 8'h18, "R6 colliding event kept", d, 8'h18);

    cur_req = "R7";
    wr(8'h06, 8'hA5);
    rd(8'h06, d); chk(d === 8'hA5, "R7 enable1 readback", d, 8'hA5);
    rd(8'h07, d); chk(d === 8'h00, "R7 unmapped read", d, 8'h00);
    repeat (2) @(negedge clk);
    chk(rdata === 8'h00, "R7 rdata holds", rdata, 0);

    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      evt = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
      req = ($urandom % 2) == 1;
      we = ($urandom % 3) == 0;
      addr = 8'(3 + $urandom % 5);
      wdata = 8'($urandom);
      @(negedge clk);
    end
    evt = '0; req = 0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule